// File: doc/BRIEF.md
# Conditional-Invert Line Word Decoder

This block sits behind a deserializer that delivers 20 received line bits per cycle, with an unknown bit offset between those chunks and the true word boundaries. It finds the word boundary by watching for the master transition that every legal word carries in its coding field. It then classifies each recovered word as data, control, idle or error and removes the sender's polarity inversion. Finally it presents the user payload with a one-cycle strobe per word.

Each line word is a 16-bit word field followed by a 4-bit coding field. The sender may send any word in true or fully complemented form to keep the line DC-balanced. The decoder looks at the coding field to learn the polarity and the word type. Data words carry 16 bits plus a flag. Control words carry 14 bits split around a two-bit marker. Idle words carry one fixed pattern. Until the aligner has seen enough well-formed words in a row, payload strobes are held back, while idle and error reports still pass through.

Top module: `cinv_line_decoder`

## Requirements
- R1: A word is bits [19:0], where bit i is the i-th bit in time. Bits [15:0] are the word field w0..w15 (w0 at bit 0) and bits [19:16] are the coding field c0..c3. Bits 17 and 18 (c1, c2) must differ, because this is the master transition. A word where they are equal raises the error strobe.
- R2: Bit 18 = 1 marks an inverted word. All 20 bits are complemented before any field below is read. Bit 18 = 0 marks a true word, which is read as received.
- R3: After un-inversion, bit 16 = 1 marks a data word. It raises the data strobe, data_o takes bits [15:0], and flag_o takes bit 19.
- R4: After un-inversion, bit 16 = 0 with bit 19 = 0 marks a control word. This is legal only when w7 = 0 and w8 = 1 after un-inversion (raw 0,1 in a true word, 1,0 in an inverted one). A legal control word raises the control strobe with ctrl_o = {w15..w9, w6..w0}. Any other marker raises the error strobe.
- R5: After un-inversion, bit 16 = 0 with bit 19 = 1 marks an idle word. It raises the idle strobe only when the un-inverted word field equals IDLE_FIELD (default 16'h00FF). This gives two idle codes, one true and one inverted. Any other field raises the error strobe.
- R6: At most one strobe is high in any cycle. A strobe lasts one cycle, and it appears in the cycle after the input chunk that completes the word.
- R7: data_o and flag_o change only together with a data strobe. ctrl_o changes only with a control strobe.
- R8: Each decoded word is taken from the 40-bit window {current chunk, previous chunk}, starting at window bit offset off. off starts at 0. When MISS_LIMIT (4) decoded words in a row lack the master transition, off advances by one, and wraps from 19 to 0.
- R9: Lock is set after LOCK_COUNT (16) consecutive decoded words that have the master transition. A boundary slip clears lock.
- R10: While unlocked, data and control words raise no strobe and leave data_o, flag_o and ctrl_o unchanged. Idle and error strobes are still reported.
- R11: Reset clears all outputs, sets off to 0 and clears lock. The first chunk after reset only fills the window and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_chunk carries 20 new line bits |
| in_chunk | input | 20 | Received bits, bit 0 earliest |
| data_o | output | 16 | Payload of the last data word |
| flag_o | output | 1 | Flag of the last data word |
| ctrl_o | output | 14 | Payload of the last control word |
| data_stb | output | 1 | One-cycle data word strobe |
| ctrl_stb | output | 1 | One-cycle control word strobe |
| idle_stb | output | 1 | One-cycle idle word strobe |
| err_stb | output | 1 | One-cycle error word strobe |

## Verification
Several properties are checked every cycle:
- the strobes are mutually exclusive, and each one follows an input chunk;
- the payload outputs hold between their own strobes;
- payload strobes appear only when lock was already set;
- the boundary offset moves only one step at a time, and only while unlocked.

Other behaviour can only be shown by the bench scenarios. These cover the exact number of misaligned words before each slip and the exact word on which lock appears, for every one of the twenty bit offsets. They also cover correct decoding of each code in both polarities, rejection of bad control markers and bad idle fields, and loss of lock after a forced slip.

// File: rtl/cidec_pkg.sv
package cidec_pkg;
    localparam int FIELD_W = 16;
    localparam int CODE_W  = 4;
    localparam int WORD_W  = FIELD_W + CODE_W;
    localparam int HALF_W  = 7;
    localparam int CTRL_W  = 2 * HALF_W;
    localparam int MT_LO   = FIELD_W + 1;
    localparam int MT_HI   = FIELD_W + 2;
    localparam int TYPE_B  = FIELD_W;
    localparam int SUB_B   = FIELD_W + 3;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CTRL = 2'd1,
        KIND_IDLE = 2'd2,
        KIND_ERR  = 2'd3
    } word_kind_e;

    typedef struct packed {
        word_kind_e         kind;
        logic               flag;
        logic [FIELD_W-1:0] field;
        logic [CTRL_W-1:0]  ctrl;
    } dec_word_t;
endpackage

// File: rtl/cidec_align.sv
module cidec_align
    import cidec_pkg::*;
#(
    parameter int MISS_LIMIT = 4,
    parameter int LOCK_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_chunk,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              locked,
    output logic [$clog2(WORD_W)-1:0] offset
);
    localparam int OFF_W  = $clog2(WORD_W);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam int GOOD_W = $clog2(LOCK_COUNT + 1);

    typedef struct packed {
        logic [WORD_W-1:0] prev;
        logic              have;
        logic [OFF_W-1:0]  off;
        logic [MISS_W-1:0] miss;
        logic [GOOD_W-1:0] good;
        logic              locked;
    } align_st_t;

    align_st_t st_q, st_d;
    logic [2*WORD_W-1:0] window;
    logic                hit;

    always_comb begin
        window     = {in_chunk, st_q.prev};
        word       = window[st_q.off +: WORD_W];
        word_valid = in_valid && st_q.have;
        hit        = word[MT_LO] ^ word[MT_HI];
        st_d       = st_q;
        if (in_valid) begin
            st_d.prev = in_chunk;
            st_d.have = 1'b1;
        end
        if (word_valid) begin
            if (hit) begin
                st_d.miss = '0;
                if (!st_q.locked) begin
                    if (st_q.good == GOOD_W'(LOCK_COUNT - 1)) begin
                        st_d.locked = 1'b1;
                        st_d.good   = '0;
                    end else begin
                        st_d.good = st_q.good + 1'b1;
                    end
                end
            end else begin
                st_d.good = '0;
                if (st_q.miss == MISS_W'(MISS_LIMIT - 1)) begin
                    st_d.miss   = '0;
                    st_d.locked = 1'b0;
                    st_d.off    = (st_q.off == OFF_W'(WORD_W - 1)) ? '0 : st_q.off + 1'b1;
                end else begin
                    st_d.miss = st_q.miss + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
    assign offset = st_q.off;
endmodule

// File: rtl/cidec_classify.sv
module cidec_classify
    import cidec_pkg::*;
#(
    parameter logic [FIELD_W-1:0] IDLE_FIELD = 16'h00FF
) (
    input  logic [WORD_W-1:0] word,
    output dec_word_t         dec
);
    logic               inv;
    logic               has_mt;
    logic               is_data;
    logic               is_idle_code;
    logic [FIELD_W-1:0] fld;

    always_comb begin
        inv          = word[MT_HI];
        has_mt       = word[MT_LO] ^ word[MT_HI];
        is_data      = word[TYPE_B] ^ inv;
        is_idle_code = word[SUB_B] ^ inv;
        fld          = word[FIELD_W-1:0] ^ {FIELD_W{inv}};
        dec.field    = fld;
        dec.flag     = is_idle_code;
        for (int i = 0; i < HALF_W; i++) begin
            dec.ctrl[i]          = fld[i];
            dec.ctrl[HALF_W + i] = fld[HALF_W + 2 + i];
        end
        if (!has_mt)
            dec.kind = KIND_ERR;
        else if (is_data)
            dec.kind = KIND_DATA;
        else if (!is_idle_code)
            dec.kind = (!fld[HALF_W] && fld[HALF_W+1]) ? KIND_CTRL : KIND_ERR;
        else
            dec.kind = (fld == IDLE_FIELD) ? KIND_IDLE : KIND_ERR;
    end
endmodule

// File: rtl/cinv_line_decoder.sv
module cinv_line_decoder
    import cidec_pkg::*;
#(
    parameter int MISS_LIMIT = 4,
    parameter int LOCK_COUNT = 16,
    parameter logic [15:0] IDLE_FIELD = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [19:0] in_chunk,
    output logic [15:0] data_o,
    output logic        flag_o,
    output logic [13:0] ctrl_o,
    output logic        data_stb,
    output logic        ctrl_stb,
    output logic        idle_stb,
    output logic        err_stb
);
    typedef struct packed {
        logic [FIELD_W-1:0] data;
        logic               flag;
        logic [CTRL_W-1:0]  ctrl;
        logic               d_stb;
        logic               c_stb;
        logic               i_stb;
        logic               e_stb;
    } out_st_t;

    out_st_t             st_q, st_d;
    logic                word_v;
    logic [WORD_W-1:0]   word_w;
    logic                lock_w;
    logic [$clog2(WORD_W)-1:0] off_w;
    dec_word_t           dec_w;

    cidec_align #(
        .MISS_LIMIT (MISS_LIMIT),
        .LOCK_COUNT (LOCK_COUNT)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_chunk   (in_chunk),
        .word_valid (word_v),
        .word       (word_w),
        .locked     (lock_w),
        .offset     (off_w)
    );

    cidec_classify #(
        .IDLE_FIELD (IDLE_FIELD)
    ) u_class (
        .word (word_w),
        .dec  (dec_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.d_stb = 1'b0;
        st_d.c_stb = 1'b0;
        st_d.i_stb = 1'b0;
        st_d.e_stb = 1'b0;
        if (word_v) begin
            case (dec_w.kind)
                KIND_DATA: if (lock_w) begin
                    st_d.data  = dec_w.field;
                    st_d.flag  = dec_w.flag;
                    st_d.d_stb = 1'b1;
                end
                KIND_CTRL: if (lock_w) begin
                    st_d.ctrl  = dec_w.ctrl;
                    st_d.c_stb = 1'b1;
                end
                KIND_IDLE: st_d.i_stb = 1'b1;
                default:   st_d.e_stb = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o   = st_q.data;
    assign flag_o   = st_q.flag;
    assign ctrl_o   = st_q.ctrl;
    assign data_stb = st_q.d_stb;
    assign ctrl_stb = st_q.c_stb;
    assign idle_stb = st_q.i_stb;
    assign err_stb  = st_q.e_stb;
endmodule

// File: rtl/cidec_checker.sv
module cidec_checker
    import cidec_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [15:0]               data_o,
    input logic                      flag_o,
    input logic [13:0]               ctrl_o,
    input logic                      data_stb,
    input logic                      ctrl_stb,
    input logic                      idle_stb,
    input logic                      err_stb,
    input logic                      locked,
    input logic [$clog2(WORD_W)-1:0] offset
);
    localparam int OFF_W = $clog2(WORD_W);

    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_stb, ctrl_stb, idle_stb, err_stb}));

    p_strobe_follows_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb || ctrl_stb || idle_stb || err_stb) |-> $past(in_valid));

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_stb |-> ($stable(data_o) && $stable(flag_o)));

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_stb |-> $stable(ctrl_o));

    p_payload_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb || ctrl_stb) |-> $past(locked));

    p_offset_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset) |-> (offset == (($past(offset) == OFF_W'(WORD_W - 1)) ?
                                         '0 : $past(offset) + 1'b1)));

    p_slip_drops_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset) |-> !locked);

    p_lock_on_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid));
endmodule

bind cinv_line_decoder cidec_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .data_o   (data_o),
    .flag_o   (flag_o),
    .ctrl_o   (ctrl_o),
    .data_stb (data_stb),
    .ctrl_stb (ctrl_stb),
    .idle_stb (idle_stb),
    .err_stb  (err_stb),
    .locked   (lock_w),
    .offset   (off_w)
);

// File: tb/cinv_line_decoder_test.sv
module cinv_line_decoder_test;
    localparam logic [15:0] IDLE_F = 16'h00FF;
    localparam logic [19:0] TRAIN  = 20'hC0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_chunk = '0;
    logic [15:0] data_o;
    logic        flag_o;
    logic [13:0] ctrl_o;
    logic        data_stb, ctrl_stb, idle_stb, err_stb;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    int          shift_k = 0;
    logic [19:0] prev_w = ~TRAIN;
    logic [15:0] exp_data = '0;
    logic [13:0] exp_ctrl = '0;
    logic        exp_flag = 1'b0;

    always #4 clk = ~clk;

    cinv_line_decoder #(
        .MISS_LIMIT (4),
        .LOCK_COUNT (16),
        .IDLE_FIELD (IDLE_F)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chunk(in_chunk),
        .data_o(data_o), .flag_o(flag_o), .ctrl_o(ctrl_o),
        .data_stb(data_stb), .ctrl_stb(ctrl_stb), .idle_stb(idle_stb), .err_stb(err_stb)
    );

    function automatic logic [3:0] stbs();
        return {data_stb, ctrl_stb, idle_stb, err_stb};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kind: 0 data, 1 control, 2 idle; inverted words are the full complement
    function automatic logic [19:0] enc(int kind, bit inv, logic [15:0] fld, bit flag);
        logic [3:0]  c;
        logic [19:0] w;
        case (kind)
            0:       c = {flag, 1'b0, 1'b1, 1'b1};
            1:       c = 4'b0010;
            default: c = 4'b1010;
        endcase
        w = {c, fld};
        return inv ? ~w : w;
    endfunction

    function automatic logic [15:0] cfield(logic [13:0] x, logic [1:0] m87);
        return {x[13:7], m87[1], m87[0], x[6:0]};
    endfunction

    task automatic send(logic [19:0] w);
        logic [39:0] pair;
        @(negedge clk);
        pair     = {w, prev_w} >> (20 - shift_k);
        in_valid = 1'b1;
        in_chunk = pair[19:0];
        prev_w   = w;
        @(posedge clk);
        #1;
    endtask

    task automatic check_word(logic [19:0] w);
        logic        inv;
        logic [19:0] u;
        logic [3:0]  es;
        string       tag;
        inv = w[18];
        u   = w ^ {20{inv}};
        if (w[17] == w[18]) begin
            es = 4'b0001; tag = "R1 no master transition";
        end else if (u[16]) begin
            es = 4'b1000; exp_data = u[15:0]; exp_flag = u[19];
            tag = inv ? "R2 R3 inverted data" : "R3 true data";
        end else if (!u[19]) begin
            if (u[8:7] == 2'b10) begin
                es = 4'b0100; exp_ctrl = {u[15:9], u[6:0]};
                tag = inv ? "R2 R4 inverted control" : "R4 true control";
            end else begin
                es = 4'b0001; tag = "R4 bad control marker";
            end
        end else if (u[15:0] == IDLE_F) begin
            es = 4'b0010; tag = inv ? "R5 inverted idle" : "R5 true idle";
        end else begin
            es = 4'b0001; tag = "R5 bad idle field";
        end
        check({tag, " strobes R6"}, 32'(stbs()), 32'(es));
        check({tag, " data_o R7"}, 32'(data_o), 32'(exp_data));
        check({tag, " flag_o R7"}, 32'(flag_o), 32'(exp_flag));
        check({tag, " ctrl_o R7"}, 32'(ctrl_o), 32'(exp_ctrl));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset strobes", 32'(stbs()), 0);
        check("R11 reset data_o", 32'(data_o), 0);
        check("R11 reset ctrl_o", 32'(ctrl_o), 0);
        check("R11 reset flag_o", 32'(flag_o), 0);
        exp_data = '0; exp_ctrl = '0; exp_flag = 1'b0;
        prev_w = ~TRAIN;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_offset(int k);
        logic [19:0] tw [12];
        logic [19:0] last;
        logic [19:0] bad;
        shift_k = k;
        do_reset();
        for (int m = 0; m <= 4 * k + 16; m++) begin
            send((m % 2 == 0) ? TRAIN : ~TRAIN);
            if (m == 0)
                check("R11 first chunk gives no strobe", 32'(stbs()), 0);
            else if (m - 1 < 4 * k)
                check("R8 misaligned word reports error", 32'(stbs()), 32'(4'b0001));
            else
                check("R10 unlocked good word gives no strobe", 32'(stbs()), 0);
        end
        tw[0]  = enc(0, 1'b0, 16'($urandom), 1'b0);
        tw[1]  = enc(0, 1'b1, 16'($urandom), 1'b1);
        tw[2]  = enc(1, 1'b0, cfield(14'($urandom), 2'b10), 1'b0);
        tw[3]  = enc(2, 1'b0, IDLE_F, 1'b0);
        tw[4]  = enc(1, 1'b1, cfield(14'($urandom), 2'b10), 1'b0);
        tw[5]  = enc(1, 1'b0, cfield(14'($urandom), 2'b11), 1'b0);
        tw[6]  = enc(1, 1'b1, cfield(14'($urandom), 2'b00), 1'b0);
        tw[7]  = enc(2, 1'b1, IDLE_F, 1'b0);
        tw[8]  = enc(2, 1'b0, IDLE_F ^ 16'h0100, 1'b0);
        tw[9]  = enc(0, 1'b0, 16'($urandom), 1'b1);
        tw[10] = enc(0, 1'b1, 16'($urandom), 1'b0) ^ 20'h40000;
        tw[11] = enc(0, 1'b1, 16'($urandom), 1'b1);
        for (int i = 0; i < 12; i++) begin
            last = prev_w;
            send(tw[i]);
            check_word(last);
        end
        bad = enc(0, 1'b0, 16'h1234, 1'b0) ^ 20'h40000;
        for (int i = 0; i < 5; i++) begin
            last = prev_w;
            send((i < 4) ? bad : enc(0, 1'b0, 16'hA5A5, 1'b1));
            check_word(last);
        end
        send(enc(1, 1'b0, cfield(14'h1555, 2'b10), 1'b0));
        check("R9 lock lost after slip: no payload strobe", 32'({data_stb, ctrl_stb}), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int k = 0; k < 20; k++) run_offset(k);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule